// File: doc/BRIEF.md
# Escaped Byte-Stream Message Deframer

This block sits between a host-side byte channel and a message mailbox. Bytes arrive over a valid/ready handshake and may contain three reserved values. 0xA0 closes a message. 0xA1 closes a command. 0xAA announces that the following byte was altered in transit. The block restores altered bytes, counts them, keeps a running 8-bit sum and writes each stored byte into the mailbox buffer through a simple write port.

When a message is closed, the block raises an attention pulse toward the mailbox. It then either accepts the frame or rejects it. A frame is rejected when it is too short or when its bytes, including the trailing checksum, do not sum to zero modulo 256. An accepted frame is announced with a ready pulse and a length that excludes the checksum. The first two bytes in the buffer are already exchanged when the frame is announced. The block then refuses input until the mailbox pulses its clear line. A closed command is discarded without interpretation. Framing faults are reported as one-cycle error pulses, and each fault returns the receiver to an empty state.

Top module: `ipmi_deframer`

## Requirements
- R1: A received 0xAA sets an escape flag. The next ordinary byte is stored with bit 4 (mask 0x10) cleared, and the flag is then cleared. A 0xAA received after overflow is ignored.
- R2: Stored bytes are written one cycle after their handshake, one write per byte. Byte k goes to address k for k >= 2, byte 0 goes to address 1 and byte 1 goes to address 0.
- R3: A data byte that arrives when BUF_DEPTH bytes are already held sets an overflow flag. That byte and every later data byte are not written until the state is reset.
- R4: A terminator (0xA0 or 0xA1) arriving while the escape flag is set produces a one-cycle err_esc_o pulse and resets the receive state.
- R5: A terminator arriving after overflow produces a one-cycle err_long_o pulse and resets the receive state. This takes effect only when the escape flag is clear.
- R6: A terminator arriving with no stored bytes, no escape pending and no overflow has no effect: no pulse and no write.
- R7: A 0xA0 with one or more stored bytes and no fault pulses attn_o for one cycle, in the cycle after its handshake.
- R8: Such a frame is rejected if it holds fewer than MIN_LEN (4) bytes (err_short_o). Otherwise it is rejected if the 8-bit sum of all stored bytes is nonzero (err_sum_o). Either rejection resets the receive state.
- R9: An accepted frame pulses msg_ready_o for one cycle, together with attn_o. msg_len_o then shows the stored count minus one and holds that value until clear_i.
- R10: After acceptance, in_ready_o stays low and nothing is written until clear_i. clear_i resets all receive state and sets msg_len_o to 0. clear_i overrides a byte offered in the same cycle.
- R11: A 0xA1 with stored bytes and no fault discards them silently, and the next frame starts at an empty buffer.
- R12: After reset, in_ready_o is 1, all pulses are 0 and msg_len_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Incoming stream byte |
| in_valid_i | input | 1 | Stream byte valid |
| in_ready_o | output | 1 | Block can take a byte |
| clear_i | input | 1 | Mailbox clear pulse, resets receive state |
| buf_we_o | output | 1 | Buffer write enable |
| buf_addr_o | output | AW | Buffer write address |
| buf_wdata_o | output | 8 | Buffer write data |
| attn_o | output | 1 | Message-end attention pulse |
| msg_ready_o | output | 1 | Accepted-message pulse |
| msg_len_o | output | LW | Accepted length without checksum |
| err_esc_o | output | 1 | Terminator while escape pending |
| err_long_o | output | 1 | Terminator after overflow |
| err_short_o | output | 1 | Message below minimum length |
| err_sum_o | output | 1 | Message checksum nonzero |

## Verification
Message lengths are swept from one byte up to the full buffer. Each length is sent once with a correct checksum and once with a checksum off by one, which separates the short, checksum and accept outcomes at every size. The payloads place reserved values in the first two positions, so escaping and the byte exchange are exercised together. Overruns of one to three bytes, with an escape byte after the overrun, show that overflow ranks below a pending escape and above every message check. Empty terminators, a discarded command followed by a new message, and a clear in mid-frame each show whether the next frame starts at address zero with a clean sum.

// File: rtl/ipmi_deframer_pkg.sv
package ipmi_deframer_pkg;
  localparam logic [7:0] MSG_END  = 8'hA0;
  localparam logic [7:0] CMD_END  = 8'hA1;
  localparam logic [7:0] ESC_BYTE = 8'hAA;
  localparam logic [7:0] ESC_MASK = 8'h10;

  typedef enum logic [1:0] {
    CLS_DATA,
    CLS_ESC,
    CLS_MSG_END,
    CLS_CMD_END
  } byte_cls_e;
endpackage

// File: rtl/dfr_unescape.sv
module dfr_unescape
  import ipmi_deframer_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      fire_i,
  input  logic [7:0] byte_i,
  input  logic      ovf_i,
  input  logic      flush_i,
  output byte_cls_e cls_o,
  output logic [7:0] data_o,
  output logic      esc_o
);
  logic esc_q;

  always_comb begin
    case (byte_i)
      MSG_END:  cls_o = CLS_MSG_END;
      CMD_END:  cls_o = CLS_CMD_END;
      ESC_BYTE: cls_o = CLS_ESC;
      default:  cls_o = CLS_DATA;
    endcase
  end

  assign data_o = esc_q ? (byte_i & ~ESC_MASK) : byte_i;
  assign esc_o  = esc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) esc_q <= 1'b0;
    else if (flush_i) esc_q <= 1'b0;
    else if (fire_i) begin
      if (cls_o == CLS_ESC && !ovf_i) esc_q <= 1'b1;
      else if (cls_o == CLS_DATA) esc_q <= 1'b0;
    end
  end

  // R1
  esc_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(esc_q) |-> $past(fire_i && cls_o == CLS_ESC && !ovf_i));
endmodule

// File: rtl/dfr_collect.sv
module dfr_collect #(
  parameter int unsigned BUF_DEPTH = 16,
  parameter int unsigned AW = $clog2(BUF_DEPTH),
  parameter int unsigned LW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [7:0]    data_i,
  input  logic          flush_i,
  output logic [LW-1:0] len_o,
  output logic          ovf_o,
  output logic [7:0]    sum_o,
  output logic          buf_we_o,
  output logic [AW-1:0] buf_addr_o,
  output logic [7:0]    buf_wdata_o
);
  logic [LW-1:0] len_q;
  logic          ovf_q;
  logic [7:0]    sum_q;
  logic          full;
  logic          store;
  logic [AW-1:0] slot;

  assign full  = (len_q == LW'(BUF_DEPTH));
  assign store = wr_i && !ovf_q && !full && !flush_i;

  // exchange of the first two bytes is folded into the write address
  always_comb begin
    if (len_q == '0)             slot = AW'(1);
    else if (len_q == LW'(1))    slot = '0;
    else                         slot = len_q[AW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      ovf_q <= 1'b0;
      sum_q <= '0;
    end else if (flush_i) begin
      len_q <= '0;
      ovf_q <= 1'b0;
      sum_q <= '0;
    end else if (wr_i && !ovf_q) begin
      if (full) ovf_q <= 1'b1;
      else begin
        len_q <= len_q + LW'(1);
        sum_q <= sum_q + data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_we_o    <= 1'b0;
      buf_addr_o  <= '0;
      buf_wdata_o <= '0;
    end else begin
      buf_we_o <= store;
      if (store) begin
        buf_addr_o  <= slot;
        buf_wdata_o <= data_i;
      end
    end
  end

  assign len_o = len_q;
  assign ovf_o = ovf_q;
  assign sum_o = sum_q;

  // R3
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !flush_i) |=> ovf_q);
  // R3
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= LW'(BUF_DEPTH));
  // R3
  no_write_after_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> !buf_we_o);
endmodule

// File: rtl/dfr_judge.sv
module dfr_judge #(
  parameter int unsigned LW      = 5,
  parameter int unsigned MIN_LEN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          term_i,
  input  logic          is_msg_i,
  input  logic          esc_i,
  input  logic          ovf_i,
  input  logic [LW-1:0] len_i,
  input  logic [7:0]    sum_i,
  output logic          attn_o,
  output logic          msg_ready_o,
  output logic [LW-1:0] msg_len_o,
  output logic          err_esc_o,
  output logic          err_long_o,
  output logic          err_short_o,
  output logic          err_sum_o,
  output logic          waiting_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attn_o      <= 1'b0;
      msg_ready_o <= 1'b0;
      msg_len_o   <= '0;
      err_esc_o   <= 1'b0;
      err_long_o  <= 1'b0;
      err_short_o <= 1'b0;
      err_sum_o   <= 1'b0;
      waiting_o   <= 1'b0;
    end else begin
      attn_o      <= 1'b0;
      msg_ready_o <= 1'b0;
      err_esc_o   <= 1'b0;
      err_long_o  <= 1'b0;
      err_short_o <= 1'b0;
      err_sum_o   <= 1'b0;
      if (clear_i) begin
        waiting_o <= 1'b0;
        msg_len_o <= '0;
      end else if (term_i) begin
        if (esc_i)                 err_esc_o  <= 1'b1;
        else if (ovf_i)            err_long_o <= 1'b1;
        else if (len_i != '0 && is_msg_i) begin
          attn_o <= 1'b1;
          if (len_i < LW'(MIN_LEN)) err_short_o <= 1'b1;
          else if (sum_i != 8'h00)  err_sum_o   <= 1'b1;
          else begin
            msg_ready_o <= 1'b1;
            msg_len_o   <= len_i - LW'(1);
            waiting_o   <= 1'b1;
          end
        end
      end
    end
  end

  // R4 R5 R8 R9
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({msg_ready_o, err_esc_o, err_long_o, err_short_o, err_sum_o}));
  // R7
  ready_has_attn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_ready_o |-> attn_o);
  // R8
  min_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_ready_o |-> msg_len_o >= LW'(MIN_LEN - 1));
  // R9
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waiting_o && !clear_i) |=> $stable(msg_len_o));
endmodule

// File: rtl/ipmi_deframer.sv
module ipmi_deframer
  import ipmi_deframer_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 16,
  parameter int unsigned MIN_LEN   = 4,
  localparam int unsigned AW = $clog2(BUF_DEPTH),
  localparam int unsigned LW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    in_data_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic          clear_i,
  output logic          buf_we_o,
  output logic [AW-1:0] buf_addr_o,
  output logic [7:0]    buf_wdata_o,
  output logic          attn_o,
  output logic          msg_ready_o,
  output logic [LW-1:0] msg_len_o,
  output logic          err_esc_o,
  output logic          err_long_o,
  output logic          err_short_o,
  output logic          err_sum_o
);
  byte_cls_e     cls;
  logic [7:0]    dbyte;
  logic          esc, ovf, waiting;
  logic [LW-1:0] len;
  logic [7:0]    sum;
  logic          fire, term, wr, flush;

  assign in_ready_o = ~waiting;
  assign fire  = in_valid_i & in_ready_o & ~clear_i;
  assign term  = fire & (cls == CLS_MSG_END || cls == CLS_CMD_END);
  assign wr    = fire & (cls == CLS_DATA);
  assign flush = clear_i | term;

  dfr_unescape u_unesc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .byte_i  (in_data_i),
    .ovf_i   (ovf),
    .flush_i (flush),
    .cls_o   (cls),
    .data_o  (dbyte),
    .esc_o   (esc)
  );

  dfr_collect #(.BUF_DEPTH(BUF_DEPTH), .AW(AW), .LW(LW)) u_coll (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr),
    .data_i      (dbyte),
    .flush_i     (flush),
    .len_o       (len),
    .ovf_o       (ovf),
    .sum_o       (sum),
    .buf_we_o    (buf_we_o),
    .buf_addr_o  (buf_addr_o),
    .buf_wdata_o (buf_wdata_o)
  );

  dfr_judge #(.LW(LW), .MIN_LEN(MIN_LEN)) u_judge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .term_i      (term),
    .is_msg_i    (cls == CLS_MSG_END),
    .esc_i       (esc),
    .ovf_i       (ovf),
    .len_i       (len),
    .sum_i       (sum),
    .attn_o      (attn_o),
    .msg_ready_o (msg_ready_o),
    .msg_len_o   (msg_len_o),
    .err_esc_o   (err_esc_o),
    .err_long_o  (err_long_o),
    .err_short_o (err_short_o),
    .err_sum_o   (err_sum_o),
    .waiting_o   (waiting)
  );

  // R10
  no_write_while_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> !buf_we_o);
endmodule

// File: tb/tb_ipmi_deframer.sv
`timescale 1ns/1ps
module tb_ipmi_deframer;
  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_valid = 1'b0;
  logic clear = 1'b0;
  logic in_ready, buf_we, attn, msg_ready, err_esc, err_long, err_short, err_sum;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_wdata;
  logic [LW-1:0] msg_len;

  int n_chk = 0;
  int n_fail = 0;
  int wr_total = 0;
  logic [7:0] mem [0:DEPTH-1];
  logic [7:0] pay [0:15];

  always #4 clk = ~clk;

  ipmi_deframer #(.BUF_DEPTH(DEPTH), .MIN_LEN(4)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .clear_i(clear), .buf_we_o(buf_we), .buf_addr_o(buf_addr),
    .buf_wdata_o(buf_wdata), .attn_o(attn), .msg_ready_o(msg_ready), .msg_len_o(msg_len),
    .err_esc_o(err_esc), .err_long_o(err_long), .err_short_o(err_short), .err_sum_o(err_sum)
  );

  always @(posedge clk) begin
    if (buf_we) begin
      mem[buf_addr] <= buf_wdata;
      wr_total <= wr_total + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // order: attn, ready, esc, long, short, sum
  task automatic chk_flags(input string req, input logic [5:0] exp);
    chk(req, {26'd0, attn, msg_ready, err_esc, err_long, err_short, err_sum}, {26'd0, exp});
  endtask

  task automatic send_raw(input logic [7:0] b);
    @(negedge clk);
    in_data = b;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_enc(input logic [7:0] b);
    if (b == 8'hA0 || b == 8'hA1 || b == 8'hAA) begin
      send_raw(8'hAA);
      send_raw(b | 8'h10);
    end else send_raw(b);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  // fills pay[0..n-1], last byte is the checksum (plus one when bad)
  task automatic build(input int n, input bit bad);
    logic [7:0] s;
    s = 8'h00;
    for (int k = 0; k < n - 1; k++) begin
      pay[k] = (k == 0) ? 8'hA0 : (k == 1) ? 8'hAA : 8'((n * 29 + k * 83 + 7));
      s = s + pay[k];
    end
    pay[n-1] = 8'(-s) + (bad ? 8'h01 : 8'h00);
  endtask

  task automatic send_frame(input int n, input logic [7:0] term);
    for (int k = 0; k < n; k++) send_enc(pay[k]);
    send_raw(term);
  endtask

  task automatic chk_mem(input int n);
    for (int k = 0; k < n - 1; k++) begin
      int a;
      a = (k == 0) ? 1 : (k == 1) ? 0 : k;
      chk("R2 content", {24'd0, mem[a]}, {24'd0, pay[k]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12
    chk("R12 ready", {31'd0, in_ready}, 32'd1);
    chk_flags("R12 flags", 6'b000000);
    chk("R12 len", {27'd0, msg_len}, 32'd0);
    chk("R12 we", {31'd0, buf_we}, 32'd0);
    rst_ni = 1'b1;

    // length sweep, good and bad checksum
    for (int n = 1; n <= DEPTH; n++) begin
      for (int bad = 0; bad < 2; bad++) begin
        build(n, bad[0]);
        base = wr_total;
        send_frame(n, 8'hA0);
        chk("R2 writes", wr_total - base, n);
        if (n < 4) begin
          chk_flags("R7 R8 short", 6'b100010);
          chk("R8 ready after short", {31'd0, in_ready}, 32'd1);
        end else if (bad != 0) begin
          chk_flags("R7 R8 sum", 6'b100001);
          chk("R8 ready after sum", {31'd0, in_ready}, 32'd1);
        end else begin
          chk_flags("R7 R9 accept", 6'b110000);
          chk("R9 len", {27'd0, msg_len}, n - 1);
          chk_mem(n);
          chk("R10 held", {31'd0, in_ready}, 32'd0);
          base = wr_total;
          in_data = 8'h33;
          in_valid = 1'b1;
          repeat (3) @(negedge clk);
          in_valid = 1'b0;
          chk("R10 no write held", wr_total - base, 0);
          chk("R9 pulse one cycle", {31'd0, msg_ready}, 32'd0);
          chk("R9 len kept", {27'd0, msg_len}, n - 1);
          do_clear();
          chk("R10 clear ready", {31'd0, in_ready}, 32'd1);
          chk("R10 clear len", {27'd0, msg_len}, 32'd0);
        end
      end
    end

    // overflow by 1..3 bytes, then escape and terminator
    for (int extra = 1; extra <= 3; extra++) begin
      base = wr_total;
      for (int k = 0; k < DEPTH + extra; k++) send_raw(8'(k * 7 + 1));
      send_raw(8'hAA);
      send_raw((extra == 2) ? 8'hA1 : 8'hA0);
      chk_flags("R5 R3 too long", 6'b000100);
      chk("R3 writes capped", wr_total - base, DEPTH);
    end
    build(4, 1'b0);
    send_frame(4, 8'hA0);
    chk_flags("R5 clean after long", 6'b110000);
    chk("R5 len after long", {27'd0, msg_len}, 32'd3);
    chk_mem(4);
    do_clear();

    // escape pending at terminator
    send_raw(8'h11);
    send_raw(8'h22);
    send_raw(8'hAA);
    send_raw(8'hA1);
    chk_flags("R4 esc end", 6'b001000);
    send_raw(8'hAA);
    send_raw(8'hA0);
    chk_flags("R4 esc end empty", 6'b001000);

    // empty terminators
    base = wr_total;
    send_raw(8'hA0);
    chk_flags("R6 empty msg end", 6'b000000);
    send_raw(8'hA1);
    chk_flags("R6 empty cmd end", 6'b000000);
    chk("R6 no writes", wr_total - base, 0);
    chk("R6 ready", {31'd0, in_ready}, 32'd1);

    // command discard then fresh message
    send_raw(8'h05);
    send_raw(8'h06);
    send_raw(8'h07);
    send_raw(8'hA1);
    chk_flags("R11 cmd silent", 6'b000000);
    build(5, 1'b0);
    send_frame(5, 8'hA0);
    chk_flags("R11 next accept", 6'b110000);
    chk("R11 len", {27'd0, msg_len}, 32'd4);
    chk_mem(5);
    do_clear();

    // escaped ordinary byte: 0x35 restored to 0x25
    send_raw(8'hAA);
    send_raw(8'h35);
    send_raw(8'h40);
    send_raw(8'h51);
    send_raw(8'h4A);
    send_raw(8'hA0);
    chk_flags("R1 accept", 6'b110000);
    chk("R1 restored", {24'd0, mem[1]}, 32'h25);
    chk("R1 next plain", {24'd0, mem[0]}, 32'h40);
    chk("R1 third", {24'd0, mem[2]}, 32'h51);
    do_clear();

    // clear in mid-frame
    send_raw(8'h01);
    send_raw(8'h02);
    do_clear();
    build(4, 1'b0);
    send_frame(4, 8'hA0);
    chk_flags("R10 after mid clear", 6'b110000);
    chk("R10 len after mid clear", {27'd0, msg_len}, 32'd3);
    chk_mem(4);
    do_clear();

    // clear overrides a byte in the same cycle
    base = wr_total;
    @(negedge clk);
    in_data = 8'h44;
    in_valid = 1'b1;
    clear = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    clear = 1'b0;
    @(negedge clk);
    chk("R10 clear wins", wr_total - base, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule